// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

A single general-purpose I/O port of up to 16 pins with a small register interface. Software selects per pin whether the pin drives or listens, and for driving pins whether the driver is push-pull or open-drain. An output latch holds the values to drive. Software can load the latch whole, or can set or clear selected bits through mask-based write addresses that leave the other pins untouched. Pin levels come back through a two-flop synchronizer into a read-only input register. Any pin can be handed to a peripheral, which then supplies that pin's output value and output enable in place of the GPIO logic.

The register port is a plain single-cycle interface with no back-pressure. A write is taken on every clock edge where `reg_wr` is high, and it takes effect at that edge. A read is combinational: `reg_rdata` follows `reg_addr` in the same cycle. Pins whose bit is clear in the parameter `PIN_MASK` are not implemented. Their register bits and pad signals stay at zero.

The register map uses a 3-bit address:
- 0: output latch
- 1: set-bits
- 2: clear-bits
- 3: direction
- 4: open-drain select
- 5: synchronized pin input
- 6: peripheral select
- 7: reserved

Top module: `gpio_port`

## Requirements
- R1: With direction bit = 1, open-drain bit = 0 and peripheral bit = 0, a pin drives `pad_oe` = 1 and `pad_out` = the latch bit. Address 3 (direction) is read/write.
- R2: With direction bit = 0 and peripheral bit = 0, `pad_oe` is 0 for that pin, whatever the open-drain setting.
- R3: With open-drain bit = 1 (address 4), peripheral bit = 0 and direction bit = 1, the pin behaves as follows. A latch 1 releases it (`pad_oe` = 0). A latch 0 drives it low (`pad_oe` = 1, `pad_out` = 0). In open-drain mode `pad_out` is always 0.
- R4: While `rst_n` is low, all registers clear to 0. One clock edge into reset, every `pad_oe` bit is 0.
- R5: Reserved bits return 0 on reads and ignore writes. These are the bits outside `PIN_MASK` in every register, and all of address 7. Those pins keep `pad_oe` = `pad_out` = 0.
- R6: A write to address 1 sets the latch bits that are 1 in `reg_wdata`. A write to address 2 clears them. All other latch bits keep their value. Addresses 1 and 2 read as 0.
- R7: A level on `pad_in` appears in address 5 after exactly two rising clock edges, and not after one.
- R8: With peripheral bit = 1 (address 6), `pad_out` = `alt_out` and `pad_oe` = `alt_oe` for that pin. Direction, open-drain and latch have no effect on it.
- R9: Address 0 reads the latch contents, not the pin level.
- R10: A register write takes effect at the clock edge where `reg_wr` is high, and is visible on pads and reads just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| pad_in | input | 16 | Pin levels from the pads |
| pad_out | output | 16 | Value to drive on each pad |
| pad_oe | output | 16 | Output enable per pad (1 = drive) |
| alt_out | input | 16 | Peripheral output value per pin |
| alt_oe | input | 16 | Peripheral output enable per pin |

## Verification
Two kinds of event can land in the same cycle.

The first pair is a mask-based set or clear write to the latch and an open-drain pin whose release depends on that latch bit. The bench issues such writes randomly while random direction and open-drain settings are in force. It checks `pad_oe` and `pad_out` just after the write edge against a model updated from the requirements.

The second pair is a change of peripheral selection and a concurrent change of `alt_out`/`alt_oe` or `pad_in`. Each cycle the bench randomizes the peripheral inputs and pin levels together with the register writes. It judges the pads, together with every register read, against that model, using a two-deep history of the pin levels.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LATCH  = 3'd0,
    A_SET    = 3'd1,
    A_CLR    = 3'd2,
    A_DIR    = 3'd3,
    A_ODRAIN = 3'd4,
    A_PIN    = 3'd5,
    A_PERIPH = 3'd6,
    A_RSVD   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int          W    = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      od_q,
  output logic [W-1:0]      alt_q
);
  logic [W-1:0] wmask;
  assign wmask = wdata & MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      od_q    <= '0;
      alt_q   <= '0;
    end else if (wr) begin
      case (reg_addr_e'(addr))
        A_LATCH:  latch_q <= wmask;
        A_SET:    latch_q <= latch_q | wmask;
        A_CLR:    latch_q <= latch_q & ~wmask;
        A_DIR:    dir_q   <= wmask;
        A_ODRAIN: od_q    <= wmask;
        A_PERIPH: alt_q   <= wmask;
        default:  ;
      endcase
    end
  end

  assert_set_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_SET) |=> latch_q == (($past(latch_q) | $past(wdata)) & MASK));

  assert_clr_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_CLR) |=> latch_q == ($past(latch_q) & ~$past(wdata)));

  assert_rsvd_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch_q | dir_q | od_q | alt_q) & ~MASK) == '0);

  assert_rsvd_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_RSVD) |=> $stable(latch_q) && $stable(dir_q) && $stable(od_q) && $stable(alt_q));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int           W      = 16,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] MASK   = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= pad_in & MASK;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign pin_q = stg[STAGES-1];
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
  parameter int           W    = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] od_q,
  input  logic [W-1:0] alt_q,
  input  logic [W-1:0] alt_out,
  input  logic [W-1:0] alt_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (MASK[i]) begin : g_impl
      always_comb begin
        if (alt_q[i]) begin
          pad_out[i] = alt_out[i];
          pad_oe[i]  = alt_oe[i];
        end else if (od_q[i]) begin
          pad_out[i] = 1'b0;
          pad_oe[i]  = dir_q[i] & ~latch_q[i];
        end else begin
          pad_out[i] = latch_q[i];
          pad_oe[i]  = dir_q[i];
        end
      end
    end else begin : g_rsvd
      assign pad_out[i] = 1'b0;
      assign pad_oe[i]  = 1'b0;
    end
  end

  assert_input_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (~dir_q & ~alt_q & pad_oe) == '0);

  assert_od_no_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q & ~alt_q & pad_out) == '0);

  assert_periph_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ alt_oe) | (pad_out ^ alt_out)) & alt_q & MASK) == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int           W           = 16,
  parameter int           SYNC_STAGES = 2,
  parameter logic [W-1:0] PIN_MASK    = 16'h3FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  input  logic [W-1:0]      alt_out,
  input  logic [W-1:0]      alt_oe
);
  logic [W-1:0] latch_q, dir_q, od_q, alt_q, pin_q;

  gpio_regs #(.W(W), .MASK(PIN_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .od_q(od_q), .alt_q(alt_q)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES), .MASK(PIN_MASK)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pin_q(pin_q)
  );

  gpio_drive #(.W(W), .MASK(PIN_MASK)) u_drive (
    .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .dir_q(dir_q), .od_q(od_q),
    .alt_q(alt_q), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    case (reg_addr_e'(reg_addr))
      A_LATCH:  reg_rdata = latch_q;
      A_DIR:    reg_rdata = dir_q;
      A_ODRAIN: reg_rdata = od_q;
      A_PIN:    reg_rdata = pin_q;
      A_PERIPH: reg_rdata = alt_q;
      default:  reg_rdata = '0;
    endcase
  end

  assert_reset_idle_R4: assert property (@(posedge clk)
    !rst_n |=> pad_oe == '0);

  assert_rsvd_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_RSVD || reg_addr == A_SET || reg_addr == A_CLR) |-> reg_rdata == '0);

  assert_rsvd_pads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out | reg_rdata) & ~PIN_MASK) == '0);
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int          W    = 16;
  localparam logic [15:0] MASK = 16'h3FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [15:0] pad_in = '0, pad_out, pad_oe;
  logic [15:0] alt_out = '0, alt_oe = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe)
  );

  // Reference model built from the requirements
  logic [15:0] m_lat = '0, m_dir = '0, m_od = '0, m_alt = '0, m_s1 = '0, m_s2 = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat <= '0; m_dir <= '0; m_od <= '0; m_alt <= '0; m_s1 <= '0; m_s2 <= '0;
    end else begin
      m_s1 <= pad_in & MASK;
      m_s2 <= m_s1;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_lat <= reg_wdata & MASK;
          3'd1: m_lat <= (m_lat | reg_wdata) & MASK;
          3'd2: m_lat <= m_lat & ~reg_wdata;
          3'd3: m_dir <= reg_wdata & MASK;
          3'd4: m_od  <= reg_wdata & MASK;
          3'd6: m_alt <= reg_wdata & MASK;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] exp_oe();
    logic [15:0] r;
    for (int i = 0; i < 16; i++)
      if (!MASK[i])      r[i] = 1'b0;
      else if (m_alt[i]) r[i] = alt_oe[i];
      else if (m_od[i])  r[i] = m_dir[i] & ~m_lat[i];
      else               r[i] = m_dir[i];
    return r;
  endfunction

  function automatic logic [15:0] exp_out();
    logic [15:0] r;
    for (int i = 0; i < 16; i++)
      if (!MASK[i])      r[i] = 1'b0;
      else if (m_alt[i]) r[i] = alt_out[i];
      else if (m_od[i])  r[i] = 1'b0;
      else               r[i] = m_lat[i];
    return r;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_lat;
      3'd3: return m_dir;
      3'd4: return m_od;
      3'd5: return m_s2;
      3'd6: return m_alt;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  // Compare pads and all eight reads against the model (called just after a negedge)
  task automatic check_all();
    check("R1/R2/R3/R8 pad_oe", pad_oe, exp_oe());
    check("R1/R3/R8 pad_out", pad_out, exp_out());
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a);
      #1;
      check("R5/R6/R7/R9 read", reg_rdata, exp_rd(3'(a)));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    pad_in = 16'hFFFF; alt_out = 16'hFFFF; alt_oe = 16'hFFFF;
    repeat (3) tick();
    // R4: state in reset
    check("R4 pad_oe in reset", pad_oe, 16'h0000);
    read_chk(3'd0, 16'h0000, "R4 latch in reset");
    read_chk(3'd5, 16'h0000, "R4 pin input in reset");
    rst_n = 1'b1;
    tick();

    // R1 push-pull, R10 visible right after the edge
    wr(3'd0, 16'hA5A5);
    wr(3'd3, 16'hFFFF);
    check("R1 pad_oe push-pull", pad_oe, 16'h3FFF);
    check("R1 pad_out push-pull", pad_out, 16'h25A5);
    read_chk(3'd3, 16'h3FFF, "R5 direction upper bits");

    // R9: latch readback differs from pin level
    pad_in = 16'h0000;
    tick(); tick();
    read_chk(3'd0, 16'h25A5, "R9 latch not pin");
    read_chk(3'd5, 16'h0000, "R7 pin low");

    // R7: exactly two edges
    pad_in = 16'h1234;
    tick();
    read_chk(3'd5, 16'h0000, "R7 after one edge");
    tick();
    read_chk(3'd5, 16'h1234, "R7 after two edges");

    // R3 open drain
    wr(3'd4, 16'h00FF);
    check("R3 open-drain oe", pad_oe, 16'h3F5A);
    check("R3 open-drain out", pad_out, 16'h2500);

    // R6 set/clear
    wr(3'd1, 16'h000F);
    read_chk(3'd0, 16'h25AF, "R6 set bits");
    wr(3'd2, 16'hFFF0);
    read_chk(3'd0, 16'h000F, "R6 clear bits");
    read_chk(3'd1, 16'h0000, "R6 set address reads zero");

    // R2 input hi-z
    wr(3'd3, 16'h0000);
    check("R2 inputs hi-z", pad_oe, 16'h0000);

    // R8 peripheral override
    alt_out = 16'h5555; alt_oe = 16'h0F0F;
    wr(3'd6, 16'hFF00);
    check("R8 periph oe", pad_oe, 16'h0F00);
    check("R8 periph out", pad_out, 16'h1500);

    // R5 reserved address and bits
    wr(3'd7, 16'hFFFF);
    read_chk(3'd7, 16'h0000, "R5 reserved address");
    check_all();

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      pad_in  = 16'($urandom);
      alt_out = 16'($urandom);
      alt_oe  = 16'($urandom);
      if ($urandom_range(0, 3) != 0) wr(a, 16'($urandom));
      else tick();
      check_all();
    end

    // Reset again mid-operation: R4
    rst_n = 1'b0;
    tick();
    check("R4 pad_oe after reset edge", pad_oe, 16'h0000);
    read_chk(3'd3, 16'h0000, "R4 direction cleared");
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule